// File: doc/BRIEF.md
# Reed-Solomon Key Equation Solver (Euclidean Division)

This block takes the sixteen syndromes of a (255, 239) Reed-Solomon codeword over GF(2^8), which corrects up to t = 8 symbol errors. It solves the key equation sigma(x) S(x) = omega(x) mod x^16 by repeated polynomial division, and returns the error-locator polynomial sigma(x) and the error-evaluator polynomial omega(x). The downstream root search and error-value stages use these two polynomials. Syndrome generation and those later stages are separate blocks.

One division datapath serves every iteration, and there are two polynomial register banks. One bank starts as x^16 and the other as S(x). Each clock either cancels one leading term of the dividend, or swaps the banks once the remainder has a lower degree than the divisor. The quotient terms are applied to the locator polynomial as they are produced. The run stops as soon as the current remainder has a degree below 8. Both results are then scaled so that sigma has a constant term of 1, and they are presented together with a one-cycle done pulse. Latency therefore depends on the data: fewer errors finish sooner.

Top module: `euclid_keq_solver`

## Requirements
- R1: After synchronous reset, `done`, `fail`, `sigma` and `omega` are all zero.
- R2: Arithmetic is over GF(2^8) with field polynomial 0x11D and alpha = 2. Coefficient j of S(x) (j = 0..15) sits in `syndromes[8j+7:8j]` and holds S_(j+1) = r(alpha^(j+1)). Coefficient i of sigma sits in `sigma[8i+7:8i]` (i = 0..8), and coefficient i of omega sits in `omega[8i+7:8i]` (i = 0..7).
- R3: For 1 to 8 errors at distinct positions p_k, with X_k = alpha^(p_k), `sigma` equals the product of (1 + X_k x), with constant term 1, and `fail` is 0.
- R4: For every syndrome input, `omega` equals the low 16 coefficients of sigma(x) S(x) as reported, and the coefficients 8 to 15 of that product are zero.
- R5: An all-zero syndrome vector returns sigma = 1, omega = 0 and fail = 0. `done` rises on the second rising edge after the edge that samples `start`.
- R6: Latency grows with the number of errors. A single-error codeword finishes in fewer cycles than an eight-error codeword, and every run finishes within 64 cycles.
- R7: `done` is high for exactly one cycle. `sigma`, `omega` and `fail` hold their values until the next result, even if the inputs change.
- R8: A `start` pulse while a run is in progress is ignored. The running result is unchanged, and no second `done` follows.
- R9: `fail` is 1 when the locator polynomial has a zero constant term, for example when S(x) = x^15 or S(x) = x^8. `fail` is also 1 if the locator degree would exceed 8 or if 16 bank swaps pass without termination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the syndromes and begin solving (ignored while busy) |
| syndromes | input | 128 | Sixteen 8-bit syndrome coefficients, coefficient 0 in the low byte |
| sigma | output | 72 | Normalized error-locator coefficients 0..8 |
| omega | output | 64 | Error-evaluator coefficients 0..7 (same scaling as sigma) |
| done | output | 1 | One-cycle pulse when sigma, omega and fail are updated |
| fail | output | 1 | Result is not a valid locator |

## Verification
A zero syndrome vector is the only input with a fixed latency: `done` is due two edges after the edge that samples `start`, and the bench checks that exact count. For all other inputs the latency depends on the data. The bench therefore polls `done` at each falling edge and reads `sigma`, `omega` and `fail` in the same cycle that `done` is seen, because all four are written by the same register edge. Hold and ignore checks sample at falling edges in the cycles that follow, one per cycle, until the window under test is over.

// File: rtl/ke_pkg.sv
package ke_pkg;
  localparam int KE_T = 8;
  localparam int KE_M = 8;
  localparam logic [KE_M:0] KE_POLY = 9'h11D;

  typedef enum logic [1:0] {KS_IDLE, KS_RUN, KS_NORM} ke_state_e;

  // Shift-and-add multiply with modular reduction.
  function automatic logic [KE_M-1:0] gf_mul(input logic [KE_M-1:0] x,
                                             input logic [KE_M-1:0] y);
    logic [KE_M-1:0] acc;
    logic [KE_M-1:0] sh;
    acc = '0;
    sh  = x;
    for (int i = 0; i < KE_M; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = {sh[KE_M-2:0], 1'b0} ^ (sh[KE_M-1] ? KE_POLY[KE_M-1:0] : '0);
    end
    return acc;
  endfunction

  // x^(2^M - 2) by repeated squaring; zero maps to zero.
  function automatic logic [KE_M-1:0] gf_inv_calc(input logic [KE_M-1:0] x);
    logic [KE_M-1:0] p;
    logic [KE_M-1:0] r;
    p = x;
    r = KE_M'(1);
    for (int i = 1; i < KE_M; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction
endpackage

// File: rtl/ke_inv_rom.sv
module ke_inv_rom #(
  parameter int M = ke_pkg::KE_M
) (
  input  logic [M-1:0] addr,
  output logic [M-1:0] data
);
  localparam int DEPTH = 1 << M;

  logic [M-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = ke_pkg::gf_inv_calc(M'(g));
  end

  assign data = table_q[addr];
endmodule

// File: rtl/ke_lead.sv
module ke_lead #(
  parameter int N  = 17,
  parameter int M  = ke_pkg::KE_M,
  parameter int DW = $clog2(N)
) (
  input  logic [M-1:0]  poly [N],
  output logic [DW-1:0] deg,
  output logic [M-1:0]  lead,
  output logic          zero
);
  always_comb begin
    deg  = '0;
    lead = '0;
    zero = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (poly[i] != '0) begin
        deg  = DW'(i);
        lead = poly[i];
        zero = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ke_div_step.sv
module ke_div_step #(
  parameter int T  = ke_pkg::KE_T,
  parameter int M  = ke_pkg::KE_M,
  parameter int DW = $clog2(2*T+1)
) (
  input  logic [M-1:0]  a      [2*T+1],
  input  logic [M-1:0]  b      [2*T+1],
  input  logic [M-1:0]  sa     [T+1],
  input  logic [M-1:0]  sb     [T+1],
  input  logic [M-1:0]  lead_a,
  input  logic [M-1:0]  inv_b,
  input  logic [DW-1:0] shift,
  output logic [M-1:0]  a_nxt  [2*T+1],
  output logic [M-1:0]  sa_nxt [T+1],
  output logic          sig_ovf
);
  import ke_pkg::*;

  localparam int NA = 2*T + 1;
  localparam int NS = T + 1;

  logic [M-1:0] coef;
  logic [M-1:0] pb [NA];
  logic [M-1:0] ps [NS];

  // One quotient term: lead(a) / lead(b), placed at x^shift.
  always_comb begin
    coef = gf_mul(lead_a, inv_b);
    for (int k = 0; k < NA; k++) pb[k] = gf_mul(coef, b[k]);
    for (int k = 0; k < NS; k++) ps[k] = gf_mul(coef, sb[k]);
  end

  // Remainder update: a - coef * x^shift * b.
  always_comb begin
    for (int i = 0; i < NA; i++) begin
      a_nxt[i] = a[i];
      for (int k = 0; k <= i; k++) begin
        if (int'(shift) == i - k) a_nxt[i] = a_nxt[i] ^ pb[k];
      end
    end
  end

  // Locator update: sa + coef * x^shift * sb, with overflow detection.
  always_comb begin
    sig_ovf = 1'b0;
    for (int i = 0; i < NS; i++) begin
      sa_nxt[i] = sa[i];
      for (int k = 0; k <= i; k++) begin
        if (int'(shift) == i - k) sa_nxt[i] = sa_nxt[i] ^ ps[k];
      end
    end
    for (int k = 0; k < NS; k++) begin
      if (ps[k] != '0 && (k + int'(shift)) > T) sig_ovf = 1'b1;
    end
  end
endmodule

// File: rtl/euclid_keq_solver.sv
module euclid_keq_solver #(
  parameter int T        = ke_pkg::KE_T,
  parameter int M        = ke_pkg::KE_M,
  parameter int MAX_ITER = 2*T
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2*T*M-1:0]     syndromes,
  output logic [(T+1)*M-1:0]   sigma,
  output logic [T*M-1:0]       omega,
  output logic                 done,
  output logic                 fail
);
  import ke_pkg::*;

  localparam int NA = 2*T + 1;
  localparam int NS = T + 1;
  localparam int DW = $clog2(NA);
  localparam int IW = $clog2(MAX_ITER + 1);

  ke_state_e st;

  logic [M-1:0]  a_q  [NA];
  logic [M-1:0]  b_q  [NA];
  logic [M-1:0]  sa_q [NS];
  logic [M-1:0]  sb_q [NS];
  logic [IW-1:0] iter_q;
  logic          ovf_q;
  logic          lim_q;

  logic [M-1:0]  syn_w [2*T];
  logic [DW-1:0] deg_a, deg_b, shift;
  logic [M-1:0]  lead_a, lead_b;
  logic          zero_a, zero_b;
  logic [M-1:0]  inv_addr, inv_val;
  logic [M-1:0]  a_nxt  [NA];
  logic [M-1:0]  sa_nxt [NS];
  logic          step_ovf;
  logic          can_div, finished, at_limit;
  logic [(T+1)*M-1:0] sig_pack;
  logic [T*M-1:0]     om_pack;

  for (genvar g = 0; g < 2*T; g++) begin : g_syn
    assign syn_w[g] = syndromes[g*M +: M];
  end

  ke_lead #(.N(NA), .M(M), .DW(DW)) u_lead_a (
    .poly(a_q), .deg(deg_a), .lead(lead_a), .zero(zero_a)
  );
  ke_lead #(.N(NA), .M(M), .DW(DW)) u_lead_b (
    .poly(b_q), .deg(deg_b), .lead(lead_b), .zero(zero_b)
  );

  // Single inverse table, shared by the division and the final scaling.
  assign inv_addr = (st == KS_NORM) ? sb_q[0] : lead_b;
  ke_inv_rom #(.M(M)) u_inv (.addr(inv_addr), .data(inv_val));

  assign shift    = deg_a - deg_b;
  assign can_div  = !zero_a && (deg_a >= deg_b);
  assign finished = zero_b || (deg_b < DW'(T));
  assign at_limit = (iter_q == IW'(MAX_ITER));

  ke_div_step #(.T(T), .M(M), .DW(DW)) u_div (
    .a(a_q), .b(b_q), .sa(sa_q), .sb(sb_q),
    .lead_a(lead_a), .inv_b(inv_val), .shift(shift),
    .a_nxt(a_nxt), .sa_nxt(sa_nxt), .sig_ovf(step_ovf)
  );

  for (genvar g = 0; g < NS; g++) begin : g_sig
    assign sig_pack[g*M +: M] = gf_mul(sb_q[g], inv_val);
  end
  for (genvar g = 0; g < T; g++) begin : g_om
    assign om_pack[g*M +: M] = gf_mul(b_q[g], inv_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= KS_IDLE;
      a_q    <= '{default: '0};
      b_q    <= '{default: '0};
      sa_q   <= '{default: '0};
      sb_q   <= '{default: '0};
      iter_q <= '0;
      ovf_q  <= 1'b0;
      lim_q  <= 1'b0;
      sigma  <= '0;
      omega  <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        KS_IDLE: begin
          if (start) begin
            for (int i = 0; i < NA - 1; i++) a_q[i] <= '0;
            a_q[NA-1] <= M'(1);
            for (int i = 0; i < 2*T; i++) b_q[i] <= syn_w[i];
            b_q[NA-1] <= '0;
            sa_q   <= '{default: '0};
            for (int i = 1; i < NS; i++) sb_q[i] <= '0;
            sb_q[0] <= M'(1);
            iter_q <= '0;
            ovf_q  <= 1'b0;
            lim_q  <= 1'b0;
            st     <= KS_RUN;
          end
        end
        KS_RUN: begin
          if (finished) begin
            st <= KS_NORM;
          end else if (at_limit) begin
            lim_q <= 1'b1;
            st    <= KS_NORM;
          end else if (can_div) begin
            a_q  <= a_nxt;
            sa_q <= sa_nxt;
            if (step_ovf) ovf_q <= 1'b1;
          end else begin
            a_q    <= b_q;
            b_q    <= a_q;
            sa_q   <= sb_q;
            sb_q   <= sa_q;
            iter_q <= iter_q + 1'b1;
          end
        end
        KS_NORM: begin
          sigma  <= sig_pack;
          omega  <= om_pack;
          fail   <= ovf_q | lim_q | (sb_q[0] == '0);
          done   <= 1'b1;
          iter_q <= '0;
          ovf_q  <= 1'b0;
          lim_q  <= 1'b0;
          st     <= KS_IDLE;
        end
        default: st <= KS_IDLE;
      endcase
    end
  end

  AST_INV_OK: assert property (@(posedge clk) disable iff (rst)
    (st == KS_RUN && !zero_b) |-> (gf_mul(lead_b, inv_val) == M'(1)))
    else $error("inverse table entry wrong"); // R2

  AST_DIV_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (st == KS_RUN && !finished && !at_limit && can_div) |=> (zero_a || deg_a < $past(deg_a)))
    else $error("division step did not lower the dividend degree"); // R6

  AST_SIG_FITS: assert property (@(posedge clk) disable iff (rst)
    (st == KS_RUN && !finished && can_div) |-> !step_ovf)
    else $error("locator degree exceeded t"); // R3

  AST_OMEGA_DEG: assert property (@(posedge clk) disable iff (rst)
    (st == KS_NORM && !lim_q) |-> finished)
    else $error("evaluator degree not below t at completion"); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done longer than one cycle"); // R7

  AST_RUN_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (st == KS_RUN) |=> (st != KS_IDLE))
    else $error("run left without completion"); // R8
endmodule

// File: tb/tb_euclid_keq_solver.sv
`timescale 1ns/1ps
module tb_euclid_keq_solver;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] syndromes = '0;
  logic [71:0]  sigma;
  logic [63:0]  omega;
  logic         done;
  logic         fail;

  euclid_keq_solver dut (
    .clk(clk), .rst(rst), .start(start), .syndromes(syndromes),
    .sigma(sigma), .omega(omega), .done(done), .fail(fail)
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nbad = 0;

  logic [7:0]  syn [16];
  logic [7:0]  esig [9];
  int          epos [8];
  logic [7:0]  evalv [8];
  int          nerr;
  logic [71:0] cap_sig;
  logic [63:0] cap_om;
  logic        cap_fail;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'(9'h11D) << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] gpow(input int e);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < (e % 255); i++) r = gmul(r, 8'h02);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  // Syndromes and expected locator from the error list.
  task automatic make_case();
    for (int j = 1; j <= 16; j++) begin
      logic [7:0] s;
      s = '0;
      for (int k = 0; k < nerr; k++) s = s ^ gmul(evalv[k], gpow(j * epos[k]));
      syn[j-1] = s;
    end
    for (int i = 0; i < 9; i++) esig[i] = '0;
    esig[0] = 8'h01;
    for (int k = 0; k < nerr; k++) begin
      logic [7:0] x;
      x = gpow(epos[k]);
      for (int i = 8; i >= 1; i--) esig[i] = esig[i] ^ gmul(esig[i-1], x);
    end
  endtask

  task automatic run_case(input bit inject, output int lat);
    int cnt;
    bit got;
    for (int j = 0; j < 16; j++) syndromes[j*8 +: 8] = syn[j];
    @(negedge clk);
    start = 1'b1;
    cnt = 0;
    got = 1'b0;
    lat = -1;
    while (!got && cnt < 200) begin
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (inject && cnt == 2) begin
        start = 1'b1;
        syndromes = ~syndromes;
      end
      if (done) begin
        got = 1'b1;
        lat = cnt - 1;
      end
    end
    if (!got) begin
      nchk++;
      nbad++;
      $display("FAIL R6 no done within 200 cycles actual=0 expected=1");
    end
    cap_sig  = sigma;
    cap_om   = omega;
    cap_fail = fail;
  endtask

  task automatic check_sigma(input string tag);
    logic [71:0] e;
    for (int i = 0; i < 9; i++) e[i*8 +: 8] = esig[i];
    chk(cap_sig == e, {tag, " sigma"}, 128'(cap_sig), 128'(e));
    chk(cap_fail == 1'b0, {tag, " fail"}, 128'(cap_fail), 128'(0));
  endtask

  task automatic check_key(input string tag);
    logic [127:0] e;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] p;
      p = '0;
      for (int k = 0; k <= 8 && k <= i; k++) p = p ^ gmul(cap_sig[k*8 +: 8], syn[i-k]);
      e[i*8 +: 8] = p;
    end
    chk({64'h0, cap_om} == e, tag, {64'h0, cap_om}, e);
  endtask

  initial begin
    #(4 * 150000);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int lat, lat1, lat8;
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done", 128'(done), 0);
    chk(fail == 1'b0, "R1 fail", 128'(fail), 0);
    chk(sigma == '0, "R1 sigma", 128'(sigma), 0);
    chk(omega == '0, "R1 omega", 128'(omega), 0);

    // R5 zero syndromes
    nerr = 0;
    make_case();
    run_case(1'b0, lat);
    chk(lat == 2, "R5 latency", 128'(lat), 128'(2));
    chk(cap_sig == 72'h01, "R5 sigma", 128'(cap_sig), 128'(1));
    chk(cap_om == '0, "R5 omega", 128'(cap_om), 0);
    chk(cap_fail == 1'b0, "R5 fail", 128'(cap_fail), 0);

    // R3 single error at position 0 (sigma = 1 + x), R2 packing
    nerr = 1; epos[0] = 0; evalv[0] = 8'h01;
    make_case();
    run_case(1'b0, lat1);
    check_sigma("R3 one error pos0");
    check_key("R4 one error pos0");
    chk(cap_sig == 72'h0101, "R2 packing", 128'(cap_sig), 128'h0101);

    // R3 eight errors at the top positions
    nerr = 8;
    for (int k = 0; k < 8; k++) begin epos[k] = 254 - k; evalv[k] = 8'(k + 1); end
    make_case();
    run_case(1'b0, lat8);
    check_sigma("R3 eight errors top");
    check_key("R4 eight errors top");
    chk(lat1 < lat8, "R6 fewer errors sooner", 128'(lat1), 128'(lat8));
    chk(lat8 <= 64, "R6 bound", 128'(lat8), 128'(64));

    // R3 eight errors including both ends
    nerr = 8;
    for (int k = 0; k < 8; k++) begin epos[k] = (k == 0) ? 0 : 254 - 31 * (k - 1); evalv[k] = 8'hFF - 8'(k); end
    make_case();
    run_case(1'b0, lat);
    check_sigma("R3 eight errors ends");
    check_key("R4 eight errors ends");

    // R3/R4 random correctable patterns
    for (int n = 0; n < 60; n++) begin
      nerr = 1 + int'($urandom % 8);
      for (int k = 0; k < nerr; k++) begin
        bit dup;
        do begin
          epos[k] = int'($urandom % 255);
          dup = 1'b0;
          for (int m = 0; m < k; m++) if (epos[m] == epos[k]) dup = 1'b1;
        end while (dup);
        evalv[k] = 8'(1 + ($urandom % 255));
      end
      make_case();
      run_case(1'b0, lat);
      check_sigma("R3 random");
      check_key("R4 random");
      chk(lat <= 64, "R6 random bound", 128'(lat), 128'(64));
    end

    // R4 arbitrary syndromes (mostly uncorrectable)
    for (int n = 0; n < 30; n++) begin
      for (int j = 0; j < 16; j++) syn[j] = 8'($urandom);
      run_case(1'b0, lat);
      check_key("R4 arbitrary");
      chk(cap_fail || cap_sig[7:0] == 8'h01, "R4 constant term", 128'(cap_sig[7:0]), 128'(1));
    end

    // R9 zero constant term
    for (int j = 0; j < 16; j++) syn[j] = '0;
    syn[15] = 8'h01;
    run_case(1'b0, lat);
    chk(cap_fail == 1'b1, "R9 S=x^15 fail", 128'(cap_fail), 128'(1));
    for (int j = 0; j < 16; j++) syn[j] = '0;
    syn[8] = 8'h01;
    run_case(1'b0, lat);
    chk(cap_fail == 1'b1, "R9 S=x^8 fail", 128'(cap_fail), 128'(1));

    // R8 start while busy is ignored
    nerr = 3;
    epos[0] = 10; epos[1] = 100; epos[2] = 200;
    evalv[0] = 8'h33; evalv[1] = 8'h5A; evalv[2] = 8'hC1;
    make_case();
    run_case(1'b1, lat);
    check_sigma("R8 busy start");
    begin
      bit extra;
      extra = 1'b0;
      repeat (30) begin @(negedge clk); if (done) extra = 1'b1; end
      chk(!extra, "R8 no second done", 128'(extra), 0);
    end

    // R7 single-cycle done and held outputs
    nerr = 2; epos[0] = 7; epos[1] = 77; evalv[0] = 8'h12; evalv[1] = 8'h34;
    make_case();
    run_case(1'b0, lat);
    check_sigma("R7 setup");
    @(negedge clk);
    chk(done == 1'b0, "R7 done pulse", 128'(done), 0);
    syndromes = ~syndromes;
    begin
      bit held;
      held = 1'b1;
      repeat (5) begin
        @(negedge clk);
        if (sigma != cap_sig || omega != cap_om || fail != cap_fail) held = 1'b0;
      end
      chk(held, "R7 outputs held", 128'(sigma), 128'(cap_sig));
    end

    summary();
    $finish;
  end
endmodule